// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the scan timing for a monochrome text screen. It counts whole character cells, not single pixels. It runs on the video dot clock and has a synchronous, active-high reset. Four counters run in cascade:

- a dot counter inside the current cell;
- a horizontal cell counter;
- a scan-line counter inside the current character row;
- a character-row counter.

From these counters it drives active-low horizontal and vertical sync, a character-end strobe and a data-enable. The counter values go out to the fetch and shift logic that sits downstream. That fetch path takes two character times from address to pixel. For this reason the horizontal part of the data-enable window trails the visible cell range by two cells.

Two copies of one region state machine track the line and the frame. Each copy has four states:

- `RG_ACTIVE`: visible;
- `RG_FRONT`: blank before sync;
- `RG_SYNC`: sync pulse;
- `RG_BACK`: blank after sync.

Each copy moves only on its own step strobe, and only when its counter reaches the last value of the current region. The transitions are:

- ACTIVE to FRONT after the last visible count. If the front porch has zero length, ACTIVE goes straight to SYNC.
- FRONT to SYNC after the last count before sync.
- SYNC to BACK after the last sync count. If the back porch has zero length, SYNC goes straight to ACTIVE.
- BACK to ACTIVE after the last count of the period.

With the default parameters, the vertical copy never enters `RG_BACK`.

Top module: `char_raster_gen`

## Requirements
- R1: `dot_cnt` counts 0 to 7 and then wraps to 0. `char_end` is high for exactly the one cycle in which `dot_cnt` is 7, which gives one pulse every 8 clocks.
- R2: `h_cnt` advances by one on each clock edge where `char_end` is high, and holds otherwise. It wraps from 99 to 0, so a line lasts 800 clocks.
- R3: `hsync_n` is low exactly while `h_cnt` is between 84 and 95 inclusive. That is 12 cells, or 96 clocks per line.
- R4: `scan_cnt` advances at the edge that ends a line (`char_end` high with `h_cnt` at 99), and holds otherwise. It wraps from 19 to 0.
- R5: `row_cnt` advances at the edge where `scan_cnt` wraps, and wraps from 25 to 0. With default parameters, a frame lasts 26 rows.
- R6: `vsync_n` is low exactly while `row_cnt` is 25, and high in rows 0 to 24.
- R7: `de` is high exactly when `h_cnt` is between 2 and 81 inclusive and `row_cnt` is below 24. It is low when `h_cnt` is 0 or 1.
- R8: While `rst` is sampled high, every counter is cleared to 0. At the first clock edge after `rst` is sampled low, `dot_cnt` becomes 1.
- R9: While `rst` is high, both `hsync_n` and `vsync_n` are held high, and both `de` and `char_end` are held low. This takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video dot clock |
| rst | input | 1 | Synchronous reset, active high |
| dot_cnt | output | 3 | Dot position inside the current cell |
| h_cnt | output | 7 | Horizontal cell count |
| scan_cnt | output | 5 | Scan line inside the current character row |
| row_cnt | output | 5 | Character-row count |
| char_end | output | 1 | One-cycle strobe on the last dot of each cell |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, delayed two cells to match the fetch pipeline |

## Verification
The bench compares every output in every cycle against values it derives from a cycle count taken since reset. It does this over the first full line, over the complete first character row and across a full frame wrap. Because a default-size frame is too long for the cycle budget, a second instance with two scan lines per row carries the frame-wrap and vertical-sync checks. Pulse counts over one line separate a shifted or stretched sync or data-enable window from a correct one, and the edge cells 1, 2, 81 and 82 separate the two-cell delay from an undelayed window. Reset is raised in the middle of the visible area and again inside both sync pulses. This shows that the outputs are forced at once, and not only after the counters clear.

// File: rtl/crg_pkg.sv
package crg_pkg;

    // Position of a counter inside its period
    typedef enum logic [1:0] {
        RG_ACTIVE = 2'd0,
        RG_FRONT  = 2'd1,
        RG_SYNC   = 2'd2,
        RG_BACK   = 2'd3
    } region_e;

endpackage

// File: rtl/crg_wrap_counter.sv
// Modulo counter with an enable; flags its final value
module crg_wrap_counter #(
    parameter int MODULUS = 8,
    parameter int W       = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         at_last
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (en) begin
            count <= at_last ? '0 : count + 1'b1;
        end
    end

    assign at_last = (count == LAST);

endmodule

// File: rtl/crg_region_fsm.sv
// Tracks visible / front porch / sync / back porch for one counter
module crg_region_fsm
    import crg_pkg::*;
#(
    parameter int W          = 7,
    parameter int VIS        = 80,
    parameter int SYNC_START = 84,
    parameter int SYNC_LEN   = 12,
    parameter int TOTAL      = 100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] count,
    output logic         in_view,
    output logic         in_sync
);

    localparam logic [W-1:0] LAST_VIS   = W'(VIS - 1);
    localparam logic [W-1:0] LAST_FRONT = W'(SYNC_START - 1);
    localparam logic [W-1:0] LAST_SYNC  = W'(SYNC_START + SYNC_LEN - 1);
    localparam logic [W-1:0] LAST_ALL   = W'(TOTAL - 1);
    localparam bit NO_FRONT = (SYNC_START == VIS);
    localparam bit NO_BACK  = (SYNC_START + SYNC_LEN == TOTAL);

    region_e state_q;
    region_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RG_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_ACTIVE: if (step && count == LAST_VIS)
                           state_d = NO_FRONT ? RG_SYNC : RG_FRONT;
            RG_FRONT:  if (step && count == LAST_FRONT)
                           state_d = RG_SYNC;
            RG_SYNC:   if (step && count == LAST_SYNC)
                           state_d = NO_BACK ? RG_ACTIVE : RG_BACK;
            RG_BACK:   if (step && count == LAST_ALL)
                           state_d = RG_ACTIVE;
        endcase
    end

    // Outputs
    always_comb begin
        in_view = (state_q == RG_ACTIVE);
        in_sync = (state_q == RG_SYNC);
    end

endmodule

// File: rtl/char_raster_gen.sv
module char_raster_gen #(
    parameter int DOTS_PER_CHAR = 8,
    parameter int H_TOTAL       = 100,
    parameter int H_VISIBLE     = 80,
    parameter int H_SYNC_START  = 84,
    parameter int H_SYNC_LEN    = 12,
    parameter int LINES_PER_ROW = 20,
    parameter int V_TOTAL       = 26,
    parameter int V_VISIBLE     = 24,
    parameter int V_SYNC_START  = 25,
    parameter int V_SYNC_LEN    = 1,
    parameter int PIPE_DELAY    = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    output logic [$clog2(DOTS_PER_CHAR)-1:0] dot_cnt,
    output logic [$clog2(H_TOTAL)-1:0]       h_cnt,
    output logic [$clog2(LINES_PER_ROW)-1:0] scan_cnt,
    output logic [$clog2(V_TOTAL)-1:0]       row_cnt,
    output logic                             char_end,
    output logic                             hsync_n,
    output logic                             vsync_n,
    output logic                             de
);

    localparam int DW = $clog2(DOTS_PER_CHAR);
    localparam int HW = $clog2(H_TOTAL);
    localparam int SW = $clog2(LINES_PER_ROW);
    localparam int VW = $clog2(V_TOTAL);

    logic dot_last, h_last, scan_last, row_last_unused;
    logic cell_end, line_end, row_end;
    logic h_view, h_sync, v_view, v_sync;
    logic de_h;

    assign cell_end = dot_last;
    assign line_end = cell_end & h_last;
    assign row_end  = line_end & scan_last;

    // Counter cascade
    crg_wrap_counter #(.MODULUS(DOTS_PER_CHAR), .W(DW)) u_dot (
        .clk(clk), .rst(rst), .en(1'b1), .count(dot_cnt), .at_last(dot_last)
    );
    crg_wrap_counter #(.MODULUS(H_TOTAL), .W(HW)) u_hcnt (
        .clk(clk), .rst(rst), .en(cell_end), .count(h_cnt), .at_last(h_last)
    );
    crg_wrap_counter #(.MODULUS(LINES_PER_ROW), .W(SW)) u_scan (
        .clk(clk), .rst(rst), .en(line_end), .count(scan_cnt), .at_last(scan_last)
    );
    crg_wrap_counter #(.MODULUS(V_TOTAL), .W(VW)) u_row (
        .clk(clk), .rst(rst), .en(row_end), .count(row_cnt), .at_last(row_last_unused)
    );

    // Region trackers
    crg_region_fsm #(
        .W(HW), .VIS(H_VISIBLE), .SYNC_START(H_SYNC_START),
        .SYNC_LEN(H_SYNC_LEN), .TOTAL(H_TOTAL)
    ) u_hfsm (
        .clk(clk), .rst(rst), .step(cell_end), .count(h_cnt),
        .in_view(h_view), .in_sync(h_sync)
    );
    crg_region_fsm #(
        .W(VW), .VIS(V_VISIBLE), .SYNC_START(V_SYNC_START),
        .SYNC_LEN(V_SYNC_LEN), .TOTAL(V_TOTAL)
    ) u_vfsm (
        .clk(clk), .rst(rst), .step(row_end), .count(row_cnt),
        .in_view(v_view), .in_sync(v_sync)
    );

    // Horizontal visibility delayed by whole cells to line up with the fetch path
    generate
        if (PIPE_DELAY == 0) begin : g_nodelay
            assign de_h = h_view;
        end else if (PIPE_DELAY == 1) begin : g_delay1
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst)           stage_q <= 1'b0;
                else if (cell_end) stage_q <= h_view;
            end
            assign de_h = stage_q;
        end else begin : g_delayn
            logic [PIPE_DELAY-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst)           stage_q <= '0;
                else if (cell_end) stage_q <= {stage_q[PIPE_DELAY-2:0], h_view};
            end
            assign de_h = stage_q[PIPE_DELAY-1];
        end
    endgenerate

    // Outputs, forced quiet while reset is high
    always_comb begin
        char_end = ~rst & cell_end;
        hsync_n  = rst | ~h_sync;
        vsync_n  = rst | ~v_sync;
        de       = ~rst & de_h & v_view;
    end

    // The row counter's final-value flag has no consumer
    logic unused_ok;
    assign unused_ok = row_last_unused;

endmodule

// File: rtl/crg_checker.sv
module crg_checker #(
    parameter int DOTS_PER_CHAR = 8,
    parameter int H_TOTAL       = 100,
    parameter int H_VISIBLE     = 80,
    parameter int H_SYNC_START  = 84,
    parameter int H_SYNC_LEN    = 12,
    parameter int LINES_PER_ROW = 20,
    parameter int V_TOTAL       = 26,
    parameter int V_VISIBLE     = 24,
    parameter int V_SYNC_START  = 25,
    parameter int V_SYNC_LEN    = 1,
    parameter int PIPE_DELAY    = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic [$clog2(DOTS_PER_CHAR)-1:0] dot_cnt,
    input logic [$clog2(H_TOTAL)-1:0]       h_cnt,
    input logic [$clog2(LINES_PER_ROW)-1:0] scan_cnt,
    input logic [$clog2(V_TOTAL)-1:0]       row_cnt,
    input logic                             char_end,
    input logic                             hsync_n,
    input logic                             vsync_n,
    input logic                             de
);

    localparam int HW = $clog2(H_TOTAL);
    localparam int SW = $clog2(LINES_PER_ROW);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] HS_FIRST = HW'(H_SYNC_START);
    localparam logic [HW-1:0] HS_LAST  = HW'(H_SYNC_START + H_SYNC_LEN - 1);
    localparam logic [HW-1:0] DE_FIRST = HW'(PIPE_DELAY);
    localparam logic [HW-1:0] DE_LAST  = HW'(H_VISIBLE + PIPE_DELAY - 1);
    localparam logic [SW-1:0] S_LAST   = SW'(LINES_PER_ROW - 1);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] VS_FIRST = VW'(V_SYNC_START);
    localparam logic [VW-1:0] VS_LAST  = VW'(V_SYNC_START + V_SYNC_LEN - 1);
    localparam logic [VW-1:0] V_VIS    = VW'(V_VISIBLE);

    AST_DOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        char_end |=> dot_cnt == '0);  // R1
    AST_DOT_STEP: assert property (@(posedge clk) disable iff (rst)
        !char_end |=> dot_cnt == $past(dot_cnt) + 1'b1);  // R1
    AST_H_HOLD: assert property (@(posedge clk) disable iff (rst)
        !char_end |=> $stable(h_cnt));  // R2
    AST_H_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        char_end |=> h_cnt == (($past(h_cnt) == H_LAST) ? '0 : $past(h_cnt) + 1'b1));  // R2
    AST_HSYNC_SPAN: assert property (@(posedge clk) disable iff (rst)
        hsync_n == !(h_cnt >= HS_FIRST && h_cnt <= HS_LAST));  // R3
    AST_SCAN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (char_end && h_cnt == H_LAST) |=>
        scan_cnt == (($past(scan_cnt) == S_LAST) ? '0 : $past(scan_cnt) + 1'b1));  // R4
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(char_end && h_cnt == H_LAST) |=> $stable(scan_cnt));  // R4
    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (char_end && h_cnt == H_LAST && scan_cnt == S_LAST) |=>
        row_cnt == (($past(row_cnt) == V_LAST) ? '0 : $past(row_cnt) + 1'b1));  // R5
    AST_VSYNC_SPAN: assert property (@(posedge clk) disable iff (rst)
        vsync_n == !(row_cnt >= VS_FIRST && row_cnt <= VS_LAST));  // R6
    AST_DE_SPAN: assert property (@(posedge clk) disable iff (rst)
        de == (h_cnt >= DE_FIRST && h_cnt <= DE_LAST && row_cnt < V_VIS));  // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (dot_cnt == '0 && h_cnt == '0 && scan_cnt == '0 && row_cnt == '0));  // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (hsync_n && vsync_n && !de && !char_end));  // R9

endmodule

bind char_raster_gen crg_checker #(
    .DOTS_PER_CHAR(DOTS_PER_CHAR), .H_TOTAL(H_TOTAL), .H_VISIBLE(H_VISIBLE),
    .H_SYNC_START(H_SYNC_START), .H_SYNC_LEN(H_SYNC_LEN),
    .LINES_PER_ROW(LINES_PER_ROW), .V_TOTAL(V_TOTAL), .V_VISIBLE(V_VISIBLE),
    .V_SYNC_START(V_SYNC_START), .V_SYNC_LEN(V_SYNC_LEN), .PIPE_DELAY(PIPE_DELAY)
) u_chk (
    .clk(clk), .rst(rst), .dot_cnt(dot_cnt), .h_cnt(h_cnt), .scan_cnt(scan_cnt),
    .row_cnt(row_cnt), .char_end(char_end), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .de(de)
);

// File: tb/tb_char_raster_gen.sv
module tb_char_raster_gen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // Cycles since reset was last sampled low
    int unsigned k;
    always @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    logic [2:0] d_dot; logic [6:0] d_h; logic [4:0] d_scan; logic [4:0] d_row;
    logic d_ce, d_hs, d_vs, d_de;
    logic [2:0] s_dot; logic [6:0] s_h; logic [0:0] s_scan; logic [4:0] s_row;
    logic s_ce, s_hs, s_vs, s_de;

    char_raster_gen dut (
        .clk(clk), .rst(rst), .dot_cnt(d_dot), .h_cnt(d_h), .scan_cnt(d_scan),
        .row_cnt(d_row), .char_end(d_ce), .hsync_n(d_hs), .vsync_n(d_vs), .de(d_de)
    );

    // Two scan lines per row so that a whole frame fits the cycle budget
    char_raster_gen #(.LINES_PER_ROW(2)) dut_short (
        .clk(clk), .rst(rst), .dot_cnt(s_dot), .h_cnt(s_h), .scan_cnt(s_scan),
        .row_cnt(s_row), .char_end(s_ce), .hsync_n(s_hs), .vsync_n(s_vs), .de(s_de)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", what, act, exp, $time);
        end
    endtask

    task automatic cmp_one(input string who, input int lines,
                           input int dot, input int h, input int scan, input int row,
                           input int ce, input int hs, input int vs, input int dv);
        int e_dot, e_h, e_scan, e_row;
        e_dot  = int'(k % 8);
        e_h    = int'((k / 8) % 100);
        e_scan = int'((k / 800) % lines);
        e_row  = int'((k / (800 * lines)) % 26);
        chk({"R1 dot_cnt ", who}, dot, e_dot);
        chk({"R1 char_end ", who}, ce, int'(e_dot == 7));
        chk({"R2 h_cnt ", who}, h, e_h);
        chk({"R3 hsync_n ", who}, hs, int'(!(e_h >= 84 && e_h <= 95)));
        chk({"R4 scan_cnt ", who}, scan, e_scan);
        chk({"R5 row_cnt ", who}, row, e_row);
        chk({"R6 vsync_n ", who}, vs, int'(e_row != 25));
        chk({"R7 de ", who}, dv, int'(e_h >= 2 && e_h <= 81 && e_row < 24));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_one("dut", 20, int'(d_dot), int'(d_h), int'(d_scan), int'(d_row),
                int'(d_ce), int'(d_hs), int'(d_vs), int'(d_de));
        cmp_one("dut_short", 2, int'(s_dot), int'(s_h), int'(s_scan), int'(s_row),
                int'(s_ce), int'(s_hs), int'(s_vs), int'(s_de));
    endtask

    task automatic t_reset();
        repeat (4) tick();
        chk("R8 counters cleared", int'(d_dot) + int'(d_h) + int'(d_scan) + int'(d_row), 0);
        chk("R9 hsync_n in reset", int'(d_hs), 1);
        chk("R9 vsync_n in reset", int'(d_vs), 1);
        chk("R9 de in reset", int'(d_de), 0);
        chk("R9 char_end in reset", int'(d_ce), 0);
    endtask

    task automatic t_dots();
        int pulses = 0;
        rst = 1'b0;
        tick();
        chk("R8 first dot after release", int'(d_dot), 1);
        for (int i = 1; i < 64; i++) begin
            tick();
            if (d_ce) pulses++;
        end
        chk("R1 char_end pulses in 64 clocks", pulses, 8);
    endtask

    task automatic t_line();
        int hs_low = 0;
        int de_hi = 0;
        while (k < 1700) begin
            tick();
            if (k >= 800 && k < 1600) begin
                if (!d_hs) hs_low++;
                if (d_de)  de_hi++;
                if (k == 800 + 8 + 3)  chk("R7 de low at h=1", int'(d_de), 0);
                if (k == 800 + 16 + 3) chk("R7 de high at h=2", int'(d_de), 1);
                if (k == 800 + 648 + 3) chk("R7 de high at h=81", int'(d_de), 1);
                if (k == 800 + 656 + 3) chk("R7 de low at h=82", int'(d_de), 0);
            end
        end
        chk("R3 hsync low clocks per line", hs_low, 96);
        chk("R7 de high clocks per line", de_hi, 640);
    endtask

    task automatic t_rows();
        while (k < 16100) tick();
        chk("R5 row after first row", int'(d_row), 1);
        chk("R4 scan wrapped to 0", int'(d_scan), 0);
    endtask

    task automatic t_frame();
        int vs_low = 0;
        while (k < 43300) begin
            tick();
            if (!s_vs) vs_low++;
        end
        chk("R6 vsync low clocks per frame", vs_low, 1600);
        chk("R5 row after frame wrap", int'(s_row), 1);
    endtask

    task automatic t_reset_mid();
        while (((k / 8) % 100) != 40) tick();
        chk("R7 de high before reset", int'(d_de), 1);
        rst = 1'b1;
        #1;
        chk("R9 de forced low at once", int'(d_de), 0);
        repeat (3) tick();
        chk("R8 counters cleared mid-frame", int'(d_dot) + int'(d_h) + int'(d_scan) + int'(d_row), 0);
        rst = 1'b0;
        repeat (20) tick();
    endtask

    task automatic t_sync_gate();
        while (k < 40680) tick();
        chk("R3 hsync low before reset", int'(d_hs), 0);
        chk("R6 vsync low before reset", int'(s_vs), 0);
        rst = 1'b1;
        #1;
        chk("R9 hsync_n forced high", int'(d_hs), 1);
        chk("R9 vsync_n forced high", int'(s_vs), 1);
        repeat (2) tick();
        rst = 1'b0;
        repeat (20) tick();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_dots();
        t_line();
        t_rows();
        t_frame();
        t_reset_mid();
        t_sync_gate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule